// File: doc/BRIEF.md
# Two-Channel Envelope Level Meter

This block follows the average magnitude of two audio channels taken after the processing chain, so that the power profile of the output can be observed. Each channel has its own path. A signed sample arrives with a valid strobe. The path rectifies the sample, scales the magnitude into a 32-bit level word, and folds it into a one-pole leaky average: the new level is a·|x| plus (1−a) times the previous level.

Each channel keeps its own 32-bit level register, and that register changes only when a sample is accepted. A small read port returns either channel's level when given a fixed register address. The smoothing coefficient is a build-time parameter. Its complement is derived from it, so the two weights always sum to exactly one.

Top module: `env_level_meter`

## Requirements
- R1: While `rst_n` is low, both level registers and `rd_data` are zero. They stay zero after reset until a sample is accepted or a read is made.
- R2: Rectification ignores sign. Feeding +v on one channel and −v on the other, in any sequence of signs, gives identical levels.
- R3: The most negative sample, 0x800000, rectifies to magnitude 0x7FFFFF, the same as the most positive sample. It does not wrap.
- R4: A sample x is 24-bit two's complement and the coefficient COEF is an unsigned fraction with 23 fractional bits. On an accepted sample, with m = |x|·2^9, the level becomes (COEF·m + (2^23−COEF)·y + 2^22) >> 23.
- R5: A channel's level changes only on a clock edge where that channel's valid strobe is high. The other channel's strobe and data have no effect on it.
- R6: No level ever exceeds full scale, 0xFFFFFE00, even under a sustained full-scale input.
- R7: A read at address 0x6B returns channel A and a read at 0x6C returns channel B. `rd_data` shows the value the level held on the clock edge that sampled `rd_en`, one cycle after the request, even if that same edge updates the level.
- R8: A read at any other address returns zero.
- R9: While `rd_en` is low, `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_a_vld | input | 1 | Channel A sample strobe |
| smp_a | input | 24 | Channel A sample, two's complement |
| smp_b_vld | input | 1 | Channel B sample strobe |
| smp_b | input | 24 | Channel B sample, two's complement |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 32 | Captured level word |

## Verification
An accepted sample changes its channel's level on the same clock edge that samples the strobe. A read is captured on the edge that samples `rd_en` and shows on `rd_data` until the next read. A level written by a sample can therefore first be seen through a read issued in the cycle after that sample. The bench drives inputs on falling edges and updates its model for the rising edge that follows. It reads `rd_data` one full cycle after the request, and it checks the same-edge case of R7 against the model value from before the update.

// File: rtl/env_meter_pkg.sv
package env_meter_pkg;
  localparam int unsigned SMP_W_DEF  = 24;
  localparam int unsigned LVL_W_DEF  = 32;
  localparam int unsigned FRAC_W_DEF = 23;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned NUM_CH     = 2;

  // Decoded read target
  typedef struct packed {
    logic hit;
    logic idx;
  } rd_sel_t;
endpackage

// File: rtl/env_rect.sv
module env_rect #(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  smp_i,
  output logic [OUT_W-1:0] mag_o
);
  localparam int unsigned MAG_W = IN_W - 1;
  localparam int unsigned PAD_W = OUT_W - MAG_W;

  logic [IN_W-1:0]  neg_w;
  logic             is_min_w;
  logic [MAG_W-1:0] mag_w;

  assign neg_w    = (~smp_i) + IN_W'(1);
  assign is_min_w = smp_i[IN_W-1] & ~(|smp_i[IN_W-2:0]);

  always_comb begin
    if (is_min_w)          mag_w = {MAG_W{1'b1}};
    else if (smp_i[IN_W-1]) mag_w = neg_w[MAG_W-1:0];
    else                   mag_w = smp_i[MAG_W-1:0];
  end

  // Left-align the magnitude in the level word
  assign mag_o = {mag_w, {PAD_W{1'b0}}};
endmodule

// File: rtl/env_smooth.sv
module env_smooth #(
  parameter int unsigned LVL_W  = 32,
  parameter int unsigned FRAC_W = 23,
  parameter logic [FRAC_W:0] COEF = 24'h080000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [LVL_W-1:0] mag_i,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int unsigned PROD_W = LVL_W + FRAC_W + 1;
  localparam logic [FRAC_W:0] ONE_C  = {1'b1, {FRAC_W{1'b0}}};
  localparam logic [FRAC_W:0] CMPL_C = ONE_C - COEF;
  localparam logic [PROD_W-1:0] HALF_C = PROD_W'(ONE_C >> 1);

  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [PROD_W-1:0] w_in, w_fb, acc_sum;

  always_comb begin
    w_in    = PROD_W'(mag_i) * PROD_W'(COEF);
    w_fb    = PROD_W'(lvl_q) * PROD_W'(CMPL_C);
    acc_sum = w_in + w_fb + HALF_C;
    lvl_d   = acc_sum[FRAC_W +: LVL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl_q <= '0;
    else if (en_i) lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/env_rd_port.sv
module env_rd_port
  import env_meter_pkg::*;
#(
  parameter int unsigned LVL_W  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'h6B,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'h6C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [LVL_W-1:0]  lvl_a_i,
  input  logic [LVL_W-1:0]  lvl_b_i,
  output logic [LVL_W-1:0]  rd_data_o
);
  rd_sel_t          sel_w;
  logic [LVL_W-1:0] data_d, data_q;

  always_comb begin
    sel_w.hit = (rd_addr_i == ADDR_A) || (rd_addr_i == ADDR_B);
    sel_w.idx = (rd_addr_i == ADDR_B);
    if (!sel_w.hit)     data_d = '0;
    else if (sel_w.idx) data_d = lvl_b_i;
    else                data_d = lvl_a_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (rd_en_i) data_q <= data_d;
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/env_level_meter.sv
module env_level_meter
  import env_meter_pkg::*;
#(
  parameter int unsigned SMP_W  = SMP_W_DEF,
  parameter int unsigned LVL_W  = LVL_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter logic [FRAC_W:0] COEF = 24'h080000,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'h6B,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'h6C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_a_vld,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic              smp_b_vld,
  input  logic [SMP_W-1:0]  smp_b,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LVL_W-1:0]  rd_data
);
  logic [SMP_W-1:0] smp_w [NUM_CH];
  logic             vld_w [NUM_CH];
  logic [LVL_W-1:0] mag_w [NUM_CH];
  logic [LVL_W-1:0] lvl_w [NUM_CH];
  logic [LVL_W-1:0] lvl_a_w, lvl_b_w;

  assign smp_w[0] = smp_a;
  assign smp_w[1] = smp_b;
  assign vld_w[0] = smp_a_vld;
  assign vld_w[1] = smp_b_vld;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    env_rect #(.IN_W(SMP_W), .OUT_W(LVL_W)) u_rect (
      .smp_i (smp_w[ch]),
      .mag_o (mag_w[ch])
    );
    env_smooth #(.LVL_W(LVL_W), .FRAC_W(FRAC_W), .COEF(COEF)) u_smooth (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (vld_w[ch]),
      .mag_i (mag_w[ch]),
      .lvl_o (lvl_w[ch])
    );
  end

  assign lvl_a_w = lvl_w[0];
  assign lvl_b_w = lvl_w[1];

  env_rd_port #(
    .LVL_W(LVL_W), .ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .lvl_a_i   (lvl_a_w),
    .lvl_b_i   (lvl_b_w),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/env_level_meter_chk.sv
module env_level_meter_chk #(
  parameter int unsigned LVL_W  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [LVL_W-1:0] FULL = 32'hFFFFFE00,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'h6B,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'h6C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vld_a,
  input logic              vld_b,
  input logic [LVL_W-1:0]  lvl_a,
  input logic [LVL_W-1:0]  lvl_b,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [LVL_W-1:0]  rd_data
);
  // R5
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_a |=> $stable(lvl_a));
  // R5
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_b |=> $stable(lvl_b));
  // R6
  full_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_a <= FULL);
  // R6
  full_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_b <= FULL);
  // R7
  read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_A) |=> rd_data == $past(lvl_a));
  // R7
  read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_B) |=> rd_data == $past(lvl_b));
  // R8
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != ADDR_A && rd_addr != ADDR_B) |=> rd_data == '0);
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind env_level_meter env_level_meter_chk #(
  .LVL_W(LVL_W), .ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .vld_a   (smp_a_vld),
  .vld_b   (smp_b_vld),
  .lvl_a   (lvl_a_w),
  .lvl_b   (lvl_b_w),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/env_level_meter_test.sv
`timescale 1ns/1ps
module env_level_meter_test;
  localparam longint COEF_V = 64'h80000;
  localparam longint ONE_V  = 64'h800000;
  localparam logic [7:0] AD_A = 8'h6B;
  localparam logic [7:0] AD_B = 8'h6C;
  localparam logic [31:0] FULL = 32'hFFFFFE00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_a_vld, smp_b_vld, rd_en;
  logic [23:0] smp_a, smp_b;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl_a, mdl_b;

  always #4 clk = ~clk;

  env_level_meter uut (
    .clk(clk), .rst_n(rst_n),
    .smp_a_vld(smp_a_vld), .smp_a(smp_a),
    .smp_b_vld(smp_b_vld), .smp_b(smp_b),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [31:0] step_mdl(input logic [31:0] y, input logic [23:0] x);
    longint mag, m, s;
    if (x == 24'h800000) mag = 64'h7FFFFF;
    else if (x[23])      mag = longint'(~x) + 1;
    else                 mag = longint'(x);
    mag = mag & 64'hFFFFFF;
    m = mag << 9;
    s = COEF_V * m + (ONE_V - COEF_V) * longint'(y) + (ONE_V >> 1);
    return 32'(s >> 23);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_a_vld = 0; smp_b_vld = 0; rd_en = 0;
    smp_a = '0; smp_b = '0; rd_addr = '0;
    mdl_a = '0; mdl_b = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic va, input logic [23:0] xa,
                      input logic vb, input logic [23:0] xb);
    @(negedge clk);
    smp_a_vld = va; smp_a = xa; smp_b_vld = vb; smp_b = xb;
    if (va) mdl_a = step_mdl(mdl_a, xa);
    if (vb) mdl_b = step_mdl(mdl_b, xb);
    @(negedge clk);
    smp_a_vld = 0; smp_b_vld = 0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    check("R1 rd_data in reset", rd_data, 32'h0);
    rd(AD_A, v); check("R1 level A after reset", v, 32'h0);
    rd(AD_B, v); check("R1 level B after reset", v, 32'h0);
  endtask

  task automatic t_formula();
    logic [31:0] v;
    do_reset();
    push(1, 24'h100000, 0, 24'h0);
    rd(AD_A, v);
    check("R4 single step A", v, 32'h02000000);
    check("R4 model A", v, mdl_a);
    rd(AD_B, v); check("R5 B untouched by A", v, 32'h0);
    for (int i = 0; i < 10; i++) push(1, 24'h3456AB, 0, 24'h7FFFFF);
    rd(AD_A, v); check("R4 ten steps A", v, mdl_a);
  endtask

  task automatic t_hold();
    logic [31:0] v0, v1;
    rd(AD_A, v0);
    @(negedge clk); smp_a = 24'h7FFFFF; smp_b = 24'h123456;
    repeat (5) @(negedge clk);
    rd(AD_A, v1); check("R5 level held without strobe", v1, v0);
    check("R5 held equals model", v1, mdl_a);
  endtask

  task automatic t_sign();
    logic [31:0] va, vb;
    do_reset();
    for (int i = 0; i < 20; i++) push(1, 24'h2A0000, 1, 24'hD60000);
    rd(AD_A, va); rd(AD_B, vb);
    check("R2 +v vs -v", vb, va);
    check("R2 model", va, mdl_a);
    do_reset();
    for (int i = 0; i < 16; i++)
      push(1, (i % 2) ? 24'hF00000 : 24'h100000, 1, 24'h100000);
    rd(AD_A, va); rd(AD_B, vb);
    check("R2 alternating sign", va, vb);
  endtask

  task automatic t_sat();
    logic [31:0] va, vb;
    do_reset();
    push(1, 24'h800000, 1, 24'h7FFFFF);
    rd(AD_A, va); rd(AD_B, vb);
    check("R3 min saturates", va, vb);
    check("R3 value", va, 32'h0FFFFFE0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < 400; i++) push(1, 24'h800000, 0, 24'h0);
    rd(AD_A, v);
    check("R6 full-scale model", v, mdl_a);
    check("R6 not above full scale", (v <= FULL) ? 32'h1 : 32'h0, 32'h1);
    for (int i = 0; i < 8; i++) push(1, 24'h0, 0, 24'h0);
    rd(AD_A, v); check("R4 decay after step to zero", v, mdl_a);
  endtask

  task automatic t_coherent();
    logic [31:0] old_a, v;
    old_a = mdl_a;
    @(negedge clk);
    rd_en = 1; rd_addr = AD_A; smp_a_vld = 1; smp_a = 24'h400000;
    mdl_a = step_mdl(mdl_a, 24'h400000);
    @(negedge clk);
    rd_en = 0; smp_a_vld = 0;
    check("R7 read same edge as update", rd_data, old_a);
    rd(AD_A, v); check("R7 following read", v, mdl_a);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    logic [7:0] bad [4] = '{8'h00, 8'h6A, 8'h6D, 8'hFF};
    push(0, 24'h0, 1, 24'h200000);
    rd(AD_B, v); check("R7 address 0x6C is B", v, mdl_b);
    foreach (bad[i]) begin
      rd(bad[i], v); check("R8 other address reads zero", v, 32'h0);
    end
    rd(AD_A, v);
    @(negedge clk); rd_addr = AD_B;
    repeat (3) @(negedge clk);
    check("R9 rd_data holds", rd_data, mdl_a);
  endtask

  initial begin
    rst_n = 1'b0; smp_a_vld = 0; smp_b_vld = 0; rd_en = 0;
    smp_a = '0; smp_b = '0; rd_addr = '0;
    mdl_a = '0; mdl_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_formula();
    t_hold();
    t_sign();
    t_sat();
    t_full();
    t_coherent();
    t_addr();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule